// File: doc/BRIEF.md
# Timed-Unlock Vector Base Register

This block is an 8-bit control register on a small processor I/O bus that chooses where the interrupt vector table is located in program memory. The table is either at word address zero or at the first word of a boot section at the top of program memory. The boot section's size comes in on a configuration input. The block also turns an interrupt index into the word address of that interrupt's vector entry, so the core can fetch the entry directly.

Moving the table must not happen by accident. The vector-select bit therefore changes only through a two-step unlock. Software first sets a change-enable bit. It must then write the new select value, with change-enable written as zero, within a short window. From the moment change-enable is set, the block asserts an interrupt-mask output. That mask stays up until the instruction that follows the select write has retired, or until one instruction has retired after the window runs out unused.

The register also stores two plain control bits, a pull-up disable and a brown-out sleep enable, and drives each one onto its own output. A third status bit is read-only and reflects an input. The register answers at I/O address 0x35. Reads are combinational.

Top module: `vecbase_ctl`

## Requirements
- R1: After reset the register reads 0x00 (with the read-only status input low), vector select is 0 and the interrupt mask is low.
- R2: Read layout at address 0x35: bit 0 change-enable, bit 1 vector select, bit 4 pull-up disable, bit 5 brown-out sleep enable, bit 6 the status input. Bits 7, 3 and 2 always read 0. Bits 4 and 5 take the written value on every write, writes to bit 6 have no effect, and a read at any other address returns 0.
- R3: A write with bit 0 set sets change-enable. From the following cycle both change-enable and the interrupt mask read as 1.
- R4: While change-enable is set, a write with bit 0 clear copies bit 1 into vector select and clears change-enable.
- R5: Counting the arming write's clock edge as edge 0, only writes on edges 1 to 4 qualify. If none arrives, change-enable clears at edge 4, and a select write at edge 5 leaves vector select unchanged.
- R6: While change-enable is clear, a write leaves vector select unchanged, whichever value bit 1 carries.
- R7: A write with bit 0 set while change-enable is already set restarts the four-edge window and leaves vector select unchanged.
- R8: After a select write, the mask drops at the second retire pulse, counting a pulse in the write cycle itself. Retire pulses while change-enable is set are not counted.
- R9: After the window runs out, the mask drops at the first retire pulse that follows.
- R10: The vector address is base + 2 × index. The base is 0 when select is 0. When select is 1, the base is 0x4000 − (256 << bootSize) words, so bootSize 0..3 gives 0x3F00, 0x3E00, 0x3C00 and 0x3800. For example, bootSize 2 with index 25 gives 0x3C32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ioAddr | input | 6 | I/O bus address |
| ioWdata | input | 8 | I/O bus write data |
| ioWe | input | 1 | I/O bus write strobe |
| ioRdata | output | 8 | I/O bus read data (combinational) |
| instRetire | input | 1 | One-cycle pulse when an instruction completes |
| bodSleepFlag | input | 1 | Value returned in read-only bit 6 |
| bootSize | input | 2 | Boot section size code |
| irqIndex | input | 5 | Interrupt index for the vector address |
| vecAddr | output | 14 | Word address of the indexed vector entry |
| vecSel | output | 1 | Current vector-table select |
| pullupDis | output | 1 | Stored pull-up disable bit |
| bodSleepEn | output | 1 | Stored brown-out sleep enable bit |
| irqMask | output | 1 | Interrupt mask held during the unlock sequence |

## Verification
The bench lands select writes on the fourth and fifth edges after arming. A design with an off-by-one window would then accept the late write or reject the last legal one. It sends unarmed writes with bit 1 both set and clear, which catches a select bit that can be written directly. It re-arms on the last legal edge, which catches a window that is not restarted and so times out early. It places retire pulses in the select-write cycle, inside the armed window and in the cycles after a timeout. A mask that counts the wrong pulses would drop one cycle early or late, or would never drop.

// File: rtl/vecbase_pkg.sv
package vecbase_pkg;

  // Bit positions inside the control register; software depends on them.
  localparam int BIT_CE    = 0;
  localparam int BIT_SEL   = 1;
  localparam int BIT_PUD   = 4;
  localparam int BIT_BODSE = 5;
  localparam int BIT_BODS  = 6;

  // Strobes from the unlock control into the register datapath.
  typedef struct packed {
    logic ceSet;
    logic ceClr;
    logic selLoad;
  } vbStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_DRAIN = 2'd2
  } vbState_t;

endpackage

// File: rtl/vecbase_ctrl.sv
module vecbase_ctrl
  import vecbase_pkg::*;
#(
  parameter int WINDOW = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWr,
  input  logic       wrCe,
  input  logic       instRetire,
  output vbStrobe_t  strb,
  output logic       irqMask,
  output logic       ceArmed
);

  localparam int CNT_W = $clog2(WINDOW + 1);

  vbState_t         state;
  logic [CNT_W-1:0] winCnt;
  logic [1:0]       needRet;

  logic armReq;
  logic valWr;
  logic expire;

  assign armReq  = regWr && wrCe;
  assign valWr   = regWr && !wrCe;
  assign expire  = (state == ST_ARMED) && !regWr && (winCnt == CNT_W'(1));
  assign ceArmed = (state == ST_ARMED);

  always_comb begin
    strb         = '0;
    strb.ceSet   = armReq;
    strb.selLoad = (state == ST_ARMED) && valWr;
    strb.ceClr   = (state == ST_ARMED) && (valWr || expire);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      winCnt  <= '0;
      needRet <= '0;
      irqMask <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (armReq) begin
            state   <= ST_ARMED;
            winCnt  <= CNT_W'(WINDOW);
            irqMask <= 1'b1;
          end
        end
        ST_ARMED: begin
          if (armReq) begin
            winCnt <= CNT_W'(WINDOW);
          end else if (valWr) begin
            state   <= ST_DRAIN;
            needRet <= instRetire ? 2'd1 : 2'd2;
          end else if (winCnt == CNT_W'(1)) begin
            state   <= ST_DRAIN;
            needRet <= 2'd1;
          end else begin
            winCnt <= winCnt - CNT_W'(1);
          end
        end
        ST_DRAIN: begin
          if (armReq) begin
            state  <= ST_ARMED;
            winCnt <= CNT_W'(WINDOW);
          end else if (instRetire) begin
            if (needRet == 2'd1) begin
              state   <= ST_IDLE;
              irqMask <= 1'b0;
            end else begin
              needRet <= needRet - 2'd1;
            end
          end
        end
        default: begin
          state   <= ST_IDLE;
          irqMask <= 1'b0;
        end
      endcase
    end
  end

  // R3: arming raises the mask on the following cycle
  p_mask_on_arm_r3: assert property (@(posedge clk) disable iff (!rstN)
    armReq |=> irqMask);

  // R5: the window counter never leaves 1..WINDOW while armed
  p_window_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ARMED) |-> (winCnt >= CNT_W'(1) && winCnt <= CNT_W'(WINDOW)));

  // R5: an unused last window cycle ends the armed state
  p_window_expire_r5: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> (state == ST_DRAIN));

  // R8: without a retire pulse or re-arm the mask is held while draining
  p_drain_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_DRAIN) && !instRetire && !armReq) |=> irqMask);

  // R9: no mask outside an unlock sequence
  p_idle_nomask_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !irqMask);

endmodule

// File: rtl/vecbase_addr.sv
module vecbase_addr #(
  parameter int PC_W           = 14,
  parameter int IDX_W          = 5,
  parameter int BSZ_W          = 2,
  parameter int MIN_BOOT_WORDS = 256
) (
  input  logic [BSZ_W-1:0] bootSize,
  input  logic [IDX_W-1:0] irqIndex,
  input  logic             vecSel,
  output logic [PC_W-1:0]  vecAddr
);

  localparam int FLASH_WORDS = 1 << PC_W;
  localparam int NUM_SIZES   = 1 << BSZ_W;

  logic [PC_W-1:0] baseTbl [NUM_SIZES];
  logic [PC_W-1:0] baseSel;
  logic [PC_W-1:0] offset;

  // One boot base per size code: each code doubles the section.
  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_base
    assign baseTbl[k] = PC_W'(FLASH_WORDS - (MIN_BOOT_WORDS << k));
  end

  assign baseSel = vecSel ? baseTbl[bootSize] : '0;
  assign offset  = {{(PC_W - IDX_W - 1){1'b0}}, irqIndex, 1'b0};
  assign vecAddr = baseSel + offset;

endmodule

// File: rtl/vecbase_dp.sv
module vecbase_dp
  import vecbase_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  vbStrobe_t  strb,
  input  logic       regWr,
  input  logic       regHit,
  input  logic       wrSel,
  input  logic       wrPud,
  input  logic       wrBodse,
  input  logic       bodSleepFlag,
  output logic [7:0] rdData,
  output logic       vecSel,
  output logic       ceBit,
  output logic       pullupDis,
  output logic       bodSleepEn
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ceBit      <= 1'b0;
      vecSel     <= 1'b0;
      pullupDis  <= 1'b0;
      bodSleepEn <= 1'b0;
    end else begin
      if (strb.ceSet)        ceBit <= 1'b1;
      else if (strb.ceClr)   ceBit <= 1'b0;
      if (strb.selLoad)      vecSel <= wrSel;
      if (regWr) begin
        pullupDis  <= wrPud;
        bodSleepEn <= wrBodse;
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (regHit) begin
      rdData[BIT_CE]    = ceBit;
      rdData[BIT_SEL]   = vecSel;
      rdData[BIT_PUD]   = pullupDis;
      rdData[BIT_BODSE] = bodSleepEn;
      rdData[BIT_BODS]  = bodSleepFlag;
    end
  end

  // R6: select only moves when the unlock control loads it
  p_sel_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.selLoad |=> $stable(vecSel));

  // R2: reserved bits never read as one
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[7] == 1'b0) && (rdData[3:2] == 2'b00));

endmodule

// File: rtl/vecbase_ctl.sv
module vecbase_ctl
  import vecbase_pkg::*;
#(
  parameter int          IO_ADDR_W      = 6,
  parameter logic [5:0]  REG_ADDR       = 6'h35,
  parameter int          PC_W           = 14,
  parameter int          NUM_VEC        = 26,
  parameter int          WINDOW         = 4,
  parameter int          BSZ_W          = 2,
  parameter int          MIN_BOOT_WORDS = 256,
  localparam int         IDX_W          = $clog2(NUM_VEC)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [IO_ADDR_W-1:0] ioAddr,
  input  logic [7:0]           ioWdata,
  input  logic                 ioWe,
  output logic [7:0]           ioRdata,
  input  logic                 instRetire,
  input  logic                 bodSleepFlag,
  input  logic [BSZ_W-1:0]     bootSize,
  input  logic [IDX_W-1:0]     irqIndex,
  output logic [PC_W-1:0]      vecAddr,
  output logic                 vecSel,
  output logic                 pullupDis,
  output logic                 bodSleepEn,
  output logic                 irqMask
);

  logic      regHit;
  logic      regWr;
  logic      ceBit;
  logic      ceArmed;
  vbStrobe_t strb;
  logic      unusedWdata;

  assign regHit      = (ioAddr == IO_ADDR_W'(REG_ADDR));
  assign regWr       = ioWe && regHit;
  assign unusedWdata = ^{ioWdata[7:6], ioWdata[3:2]};

  vecbase_ctrl #(.WINDOW(WINDOW)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regWr      (regWr),
    .wrCe       (ioWdata[BIT_CE]),
    .instRetire (instRetire),
    .strb       (strb),
    .irqMask    (irqMask),
    .ceArmed    (ceArmed)
  );

  vecbase_dp u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .regWr        (regWr),
    .regHit       (regHit),
    .wrSel        (ioWdata[BIT_SEL]),
    .wrPud        (ioWdata[BIT_PUD]),
    .wrBodse      (ioWdata[BIT_BODSE]),
    .bodSleepFlag (bodSleepFlag),
    .rdData       (ioRdata),
    .vecSel       (vecSel),
    .ceBit        (ceBit),
    .pullupDis    (pullupDis),
    .bodSleepEn   (bodSleepEn)
  );

  vecbase_addr #(
    .PC_W           (PC_W),
    .IDX_W          (IDX_W),
    .BSZ_W          (BSZ_W),
    .MIN_BOOT_WORDS (MIN_BOOT_WORDS)
  ) u_addr (
    .bootSize (bootSize),
    .irqIndex (irqIndex),
    .vecSel   (vecSel),
    .vecAddr  (vecAddr)
  );

  // R3: the visible change-enable bit tracks the armed control state
  p_ce_track_r3: assert property (@(posedge clk) disable iff (!rstN)
    ceBit == ceArmed);

  // R3: change-enable is never visible without the mask
  p_ce_masked_r3: assert property (@(posedge clk) disable iff (!rstN)
    ceBit |-> irqMask);

  // R10: with select low, addresses stay inside the low table
  p_low_table_r10: assert property (@(posedge clk) disable iff (!rstN)
    !vecSel |-> (vecAddr < PC_W'(2 * (1 << IDX_W))));

endmodule

// File: tb/tb_vecbase_ctl.sv
module tb_vecbase_ctl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  ioAddr = 6'h35;
  logic [7:0]  ioWdata = 8'h00;
  logic        ioWe = 1'b0;
  logic [7:0]  ioRdata;
  logic        instRetire = 1'b0;
  logic        bodSleepFlag = 1'b0;
  logic [1:0]  bootSize = 2'd2;
  logic [4:0]  irqIndex = 5'd0;
  logic [13:0] vecAddr;
  logic        vecSel, pullupDis, bodSleepEn, irqMask;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  vecbase_ctl dut (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWdata(ioWdata), .ioWe(ioWe),
    .ioRdata(ioRdata), .instRetire(instRetire), .bodSleepFlag(bodSleepFlag),
    .bootSize(bootSize), .irqIndex(irqIndex), .vecAddr(vecAddr), .vecSel(vecSel),
    .pullupDis(pullupDis), .bodSleepEn(bodSleepEn), .irqMask(irqMask)
  );

  // Row: {we, wdata, retire, expected read, expected mask, expected select}
  localparam int NROW = 30;
  localparam logic [19:0] TBL [NROW] = '{
    {1'b1, 8'h01, 1'b0, 8'h01, 1'b1, 1'b0}, //  0 R3 arm
    {1'b0, 8'h00, 1'b1, 8'h01, 1'b1, 1'b0}, //  1 R8 retire while armed ignored
    {1'b1, 8'h02, 1'b0, 8'h02, 1'b1, 1'b1}, //  2 R4 select write
    {1'b0, 8'h00, 1'b1, 8'h02, 1'b1, 1'b1}, //  3 R8 first retire
    {1'b0, 8'h00, 1'b0, 8'h02, 1'b1, 1'b1}, //  4 R8 hold
    {1'b0, 8'h00, 1'b1, 8'h02, 1'b0, 1'b1}, //  5 R8 second retire drops mask
    {1'b1, 8'h03, 1'b0, 8'h03, 1'b1, 1'b1}, //  6 R3 arm, bit1 ignored
    {1'b1, 8'h00, 1'b1, 8'h00, 1'b1, 1'b0}, //  7 R4 write with retire in same cycle
    {1'b0, 8'h00, 1'b1, 8'h00, 1'b0, 1'b0}, //  8 R8 mask drops
    {1'b1, 8'h01, 1'b0, 8'h01, 1'b1, 1'b0}, //  9 R5 arm
    {1'b0, 8'h00, 1'b0, 8'h01, 1'b1, 1'b0}, // 10 R5 edge 1
    {1'b0, 8'h00, 1'b0, 8'h01, 1'b1, 1'b0}, // 11 R5 edge 2
    {1'b0, 8'h00, 1'b0, 8'h01, 1'b1, 1'b0}, // 12 R5 edge 3
    {1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0}, // 13 R5 edge 4 expires
    {1'b1, 8'h02, 1'b0, 8'h00, 1'b1, 1'b0}, // 14 R5 late write ignored
    {1'b0, 8'h00, 1'b1, 8'h00, 1'b0, 1'b0}, // 15 R9 one retire releases
    {1'b1, 8'h02, 1'b0, 8'h00, 1'b0, 1'b0}, // 16 R6 unarmed write
    {1'b1, 8'h01, 1'b0, 8'h01, 1'b1, 1'b0}, // 17 R7 arm
    {1'b0, 8'h00, 1'b0, 8'h01, 1'b1, 1'b0}, // 18 R7
    {1'b0, 8'h00, 1'b0, 8'h01, 1'b1, 1'b0}, // 19 R7
    {1'b0, 8'h00, 1'b0, 8'h01, 1'b1, 1'b0}, // 20 R7
    {1'b1, 8'h01, 1'b0, 8'h01, 1'b1, 1'b0}, // 21 R7 re-arm on edge 4
    {1'b0, 8'h00, 1'b0, 8'h01, 1'b1, 1'b0}, // 22 R7
    {1'b0, 8'h00, 1'b0, 8'h01, 1'b1, 1'b0}, // 23 R7
    {1'b0, 8'h00, 1'b0, 8'h01, 1'b1, 1'b0}, // 24 R7
    {1'b1, 8'h02, 1'b0, 8'h02, 1'b1, 1'b1}, // 25 R7 accepted on new edge 4
    {1'b0, 8'h00, 1'b1, 8'h02, 1'b1, 1'b1}, // 26 R8
    {1'b0, 8'h00, 1'b1, 8'h02, 1'b0, 1'b1}, // 27 R8
    {1'b1, 8'h30, 1'b0, 8'h32, 1'b0, 1'b1}, // 28 R2 bits 5/4, R6 select kept
    {1'b1, 8'hCC, 1'b0, 8'h02, 1'b0, 1'b1}  // 29 R2 reserved and read-only bits
  };

  function automatic string rowTag(int i);
    if (i <= 1)  return "R3/R8";
    if (i <= 5)  return "R4/R8";
    if (i <= 8)  return "R4/R8 retire-in-write";
    if (i <= 14) return "R5";
    if (i == 15) return "R9";
    if (i == 16) return "R6";
    if (i <= 27) return "R7";
    return "R2";
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic ioWrite(logic [7:0] d, logic ret);
    @(negedge clk);
    ioWe = 1'b1; ioWdata = d; instRetire = ret;
    @(negedge clk);
    ioWe = 1'b0; instRetire = 1'b0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1 reset state, observed while reset is held and after release
    check("R1 read in reset", 16'(ioRdata), 16'h00);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 read", 16'(ioRdata), 16'h00);
    check("R1 mask", 16'(irqMask), 16'h0);
    check("R1 select", 16'(vecSel), 16'h0);

    for (int i = 0; i < NROW; i++) begin
      @(negedge clk);
      ioWe = TBL[i][19]; ioWdata = TBL[i][18:11]; instRetire = TBL[i][10];
      @(posedge clk);
      #1;
      check($sformatf("%s row %0d read", rowTag(i), i), 16'(ioRdata), 16'(TBL[i][9:2]));
      check($sformatf("%s row %0d mask", rowTag(i), i), 16'(irqMask), 16'(TBL[i][1]));
      check($sformatf("%s row %0d select", rowTag(i), i), 16'(vecSel), 16'(TBL[i][0]));
    end
    @(negedge clk);
    ioWe = 1'b0; instRetire = 1'b0;

    // R2: stored bits on their outputs, status input, other address
    check("R2 pullupDis out", 16'(pullupDis), 16'h0);
    ioWrite(8'h10, 1'b0);
    check("R2 pullupDis set", 16'(pullupDis), 16'h1);
    check("R2 bodSleepEn clear", 16'(bodSleepEn), 16'h0);
    bodSleepFlag = 1'b1;
    #1;
    check("R2 status bit", 16'(ioRdata), 16'h52);
    ioWrite(8'h00, 1'b0);
    check("R2 status unaffected by write", 16'(ioRdata), 16'h42);
    ioAddr = 6'h36;
    #1;
    check("R2 other address", 16'(ioRdata), 16'h00);
    ioAddr = 6'h35;

    // R10: select is 1 here
    bootSize = 2'd2; irqIndex = 5'd0; #1;
    check("R10 size2 idx0", 16'(vecAddr), 16'h3C00);
    irqIndex = 5'd1; #1;
    check("R10 size2 idx1", 16'(vecAddr), 16'h3C02);
    irqIndex = 5'd2; #1;
    check("R10 size2 idx2", 16'(vecAddr), 16'h3C04);
    irqIndex = 5'd25; #1;
    check("R10 size2 idx25", 16'(vecAddr), 16'h3C32);
    bootSize = 2'd0; irqIndex = 5'd0; #1;
    check("R10 size0", 16'(vecAddr), 16'h3F00);
    bootSize = 2'd1; #1;
    check("R10 size1", 16'(vecAddr), 16'h3E00);
    bootSize = 2'd3; #1;
    check("R10 size3", 16'(vecAddr), 16'h3800);

    // R4 back to the low table, then R10 with select low
    ioWrite(8'h01, 1'b0);
    ioWrite(8'h00, 1'b0);
    check("R4 select cleared", 16'(vecSel), 16'h0);
    irqIndex = 5'd25; #1;
    check("R10 low idx25", 16'(vecAddr), 16'h0032);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule